// File: doc/BRIEF.md
# Under-Voltage Motion Supervisor

This block watches the supply of a stepper-motor drive and decides what the positioner may do while the supply sags and after it comes back. It runs a four-state machine: idle (Stopped), moving towards a target (GotoPos), decelerating to rest (HardStop) and powered down (ShutDown). Two supply comparator flags feed it. One says the supply is below the drop threshold. The other says it is above the recovery threshold. Both pass through a synchronizer before use. The block also takes a charge-pump failure flag, a set of overcurrent flags, a step-loss event, a hard-stop-complete handshake and the target and actual positions.

When the supply drops in the middle of a move, the block latches an under-voltage flag, asks the positioner for a hard stop and then powers the bridge down. The latched flag decides whether the pending target survives. If the flag is set, the target is kept, so the move resumes by itself once the supply has recovered. If the flag is clear when a hard stop ends, the block writes the actual position back into the target, and the move is cancelled. A latched step-loss flag, or any active hard-stop cause, blocks new motion. The latched flags are cleared only when the supply recovers from power-down.

Top module: `uv_motion_supervisor`

## Requirements
- R1: After reset, `state_o` is 0 (Stopped). `uv_flag_o`, `cpf_flag_o`, `sl_flag_o`, `pwm_en_o`, `bridge_hiz_o`, `hs_req_o` and `tgt_wr_o` are all 0. The state encoding is 0 Stopped, 1 GotoPos, 2 HardStop, 3 ShutDown.
- R2: Each supply comparator input passes through `SYNC_STAGES` flip-flops (default 2). With the default, a change at the port changes `state_o` on the third rising edge after it is applied, and not earlier.
- R3: In Stopped, a synchronized drop moves the block to ShutDown. In ShutDown, `bridge_hiz_o` is 1 and `pwm_en_o` is 0.
- R4: In GotoPos, a synchronized drop sets `uv_flag_o` and moves the block to HardStop on the same edge. A drop during HardStop also sets `uv_flag_o`.
- R5: In GotoPos, the block moves to HardStop when any of these is active: the latched under-voltage flag, the latched charge-pump fail flag, or any bit of `oc_i`. The latched charge-pump fail flag is set by `cp_fail_i`. While any of these is active, Stopped does not start a move.
- R6: In HardStop, `hs_done_i` moves the block to Stopped. In that cycle, `tgt_wr_o` is 1 and `tgt_wr_data_o` equals `actual_pos_i` if `uv_flag_o` is 0. Otherwise `tgt_wr_o` stays 0.
- R7: In Stopped with `uv_flag_o` set, the block moves to ShutDown without writing the target.
- R8: In ShutDown, a synchronized recovery moves the block to Stopped and clears the under-voltage, charge-pump fail and step-loss flags on that edge. A target that was kept then restarts the move.
- R9: In Stopped, a target different from `actual_pos_i` starts a move to GotoPos. In GotoPos, equal positions return the block to Stopped.
- R10: `step_loss_i` sets `sl_flag_o`. While `sl_flag_o` is set, Stopped never moves to GotoPos.
- R11: When recovery and drop are both active after synchronization in the same cycle, recovery wins. The drop is ignored in every state, and ShutDown is left for Stopped.
- R12: `pwm_en_o` is 1 exactly in GotoPos and HardStop. `hs_req_o` is 1 exactly in HardStop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low_i | input | 1 | Supply below drop threshold (asynchronous) |
| supply_ok_i | input | 1 | Supply above recovery threshold (asynchronous) |
| cp_fail_i | input | 1 | Charge-pump failure event |
| oc_i | input | OC_NUM | Overcurrent flags |
| step_loss_i | input | 1 | Step-loss event |
| hs_done_i | input | 1 | Positioner reports that the hard stop is complete |
| target_pos_i | input | POS_W | Current target position |
| actual_pos_i | input | POS_W | Current actual position |
| state_o | output | 2 | Supervisor state |
| pwm_en_o | output | 1 | PWM enable |
| bridge_hiz_o | output | 1 | Puts the motor bridge in high impedance |
| hs_req_o | output | 1 | Hard-stop request to the positioner |
| uv_flag_o | output | 1 | Latched under-voltage flag |
| cpf_flag_o | output | 1 | Latched charge-pump fail flag |
| sl_flag_o | output | 1 | Latched step-loss flag |
| tgt_wr_o | output | 1 | Target overwrite strobe |
| tgt_wr_data_o | output | POS_W | Value to write into the target |

## Verification
Supply drop and supply recovery can both be active in the same cycle after synchronization. The bench drives both comparator inputs high at once, first during a move and then during power-down. In GotoPos the move must carry on with no hard stop and no under-voltage flag. In ShutDown the block must return to Stopped and clear its flags. A second coincidence is a hard-stop completion while the under-voltage flag is set. That case must end the stop without a target write.

// File: rtl/uvs_pkg.sv
package uvs_pkg;
   typedef enum logic [1:0] {
      ST_STOP = 2'd0,
      ST_GOTO = 2'd1,
      ST_HARD = 2'd2,
      ST_SHUT = 2'd3
   } uvs_state_e;
endpackage

// File: rtl/uvs_sync.sv
module uvs_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] pipe [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("uvs_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '0;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[LAST];
endmodule

// File: rtl/uvs_flags.sv
module uvs_flags #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_i,
   input  logic             clr_i,
   output logic [NFLAG-1:0] flag_o
);
   if (NFLAG < 1) begin : g_bad_nflag
      $error("uvs_flags: NFLAG must be positive");
   end

   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flag_o[f] <= 1'b0;
         else if (clr_i)     flag_o[f] <= 1'b0;
         else if (set_i[f])  flag_o[f] <= 1'b1;
      end
   end
endmodule

// File: rtl/uvs_fsm.sv
module uvs_fsm
   import uvs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       drop_i,
   input  logic       rec_i,
   input  logic       hs_cause_i,
   input  logic       uv_flag_i,
   input  logic       sl_flag_i,
   input  logic       pos_differs_i,
   input  logic       hs_done_i,
   output uvs_state_e state_o,
   output logic       uv_set_o,
   output logic       flag_clr_o
);
   uvs_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_STOP: begin
            if (drop_i || uv_flag_i)
               state_d = ST_SHUT;
            else if (pos_differs_i && !sl_flag_i && !hs_cause_i)
               state_d = ST_GOTO;
         end
         ST_GOTO: begin
            if (drop_i || hs_cause_i) state_d = ST_HARD;
            else if (!pos_differs_i)  state_d = ST_STOP;
         end
         ST_HARD: begin
            if (hs_done_i) state_d = ST_STOP;
         end
         ST_SHUT: begin
            if (rec_i) state_d = ST_STOP;
         end
         default: state_d = ST_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_STOP;
      else        state_q <= state_d;
   end

   assign uv_set_o   = drop_i && (state_q == ST_GOTO || state_q == ST_HARD);
   assign flag_clr_o = rec_i && (state_q == ST_SHUT);
   assign state_o    = state_q;
endmodule

// File: rtl/uv_motion_supervisor.sv
module uv_motion_supervisor
   import uvs_pkg::*;
#(
   parameter int POS_W       = 16,
   parameter int OC_NUM      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_low_i,
   input  logic              supply_ok_i,
   input  logic              cp_fail_i,
   input  logic [OC_NUM-1:0] oc_i,
   input  logic              step_loss_i,
   input  logic              hs_done_i,
   input  logic [POS_W-1:0]  target_pos_i,
   input  logic [POS_W-1:0]  actual_pos_i,
   output logic [1:0]        state_o,
   output logic              pwm_en_o,
   output logic              bridge_hiz_o,
   output logic              hs_req_o,
   output logic              uv_flag_o,
   output logic              cpf_flag_o,
   output logic              sl_flag_o,
   output logic              tgt_wr_o,
   output logic [POS_W-1:0]  tgt_wr_data_o
);
   localparam int NFLAG  = 3;
   localparam int F_UV   = 0;
   localparam int F_CPF  = 1;
   localparam int F_SL   = 2;

   if (POS_W < 1)  begin : g_bad_pos  $error("POS_W must be positive");  end
   if (OC_NUM < 1) begin : g_bad_oc   $error("OC_NUM must be positive"); end

   logic [1:0]       cmp_sync;
   logic             low_s, ok_s, drop, hs_cause, uv_set, flag_clr;
   logic [NFLAG-1:0] flag_set, flags;
   uvs_state_e       state;

   uvs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({supply_ok_i, supply_low_i}),
      .q_o   (cmp_sync)
   );

   assign low_s = cmp_sync[0];
   assign ok_s  = cmp_sync[1];
   assign drop  = low_s && !ok_s;

   assign hs_cause = flags[F_UV] || flags[F_CPF] || (|oc_i);

   uvs_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .drop_i        (drop),
      .rec_i         (ok_s),
      .hs_cause_i    (hs_cause),
      .uv_flag_i     (flags[F_UV]),
      .sl_flag_i     (flags[F_SL]),
      .pos_differs_i (target_pos_i != actual_pos_i),
      .hs_done_i     (hs_done_i),
      .state_o       (state),
      .uv_set_o      (uv_set),
      .flag_clr_o    (flag_clr)
   );

   always_comb begin
      flag_set        = '0;
      flag_set[F_UV]  = uv_set;
      flag_set[F_CPF] = cp_fail_i;
      flag_set[F_SL]  = step_loss_i;
   end

   uvs_flags #(.NFLAG(NFLAG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_i  (flag_clr),
      .flag_o (flags)
   );

   assign state_o       = state;
   assign pwm_en_o      = (state == ST_GOTO) || (state == ST_HARD);
   assign bridge_hiz_o  = (state == ST_SHUT);
   assign hs_req_o      = (state == ST_HARD);
   assign uv_flag_o     = flags[F_UV];
   assign cpf_flag_o    = flags[F_CPF];
   assign sl_flag_o     = flags[F_SL];
   assign tgt_wr_o      = (state == ST_HARD) && hs_done_i && !flags[F_UV];
   assign tgt_wr_data_o = actual_pos_i;
endmodule

// File: rtl/uvs_checker.sv
module uvs_checker #(
   parameter int OC_NUM = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              low_s,
   input logic              ok_s,
   input logic [OC_NUM-1:0] oc_i,
   input logic              hs_done_i,
   input logic [1:0]        state_o,
   input logic              pwm_en_o,
   input logic              bridge_hiz_o,
   input logic              uv_flag_o,
   input logic              cpf_flag_o,
   input logic              sl_flag_o,
   input logic              tgt_wr_o
);
   AST_STOP_DROP_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && low_s && !ok_s) |=> state_o == 2'd3);  // R3

   AST_SHUT_NO_PWM: assert property (@(posedge clk) disable iff (!rst_n)
      bridge_hiz_o |-> !pwm_en_o);  // R3

   AST_GOTO_DROP_UV: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && low_s && !ok_s) |=> (uv_flag_o && state_o == 2'd2));  // R4

   AST_WR_ONLY_UV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_wr_o |-> (!uv_flag_o && hs_done_i && state_o == 2'd2));  // R6

   AST_REC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3 && ok_s) |=> (state_o == 2'd0 && !uv_flag_o && !cpf_flag_o && !sl_flag_o));  // R8

   AST_SL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && sl_flag_o) |=> state_o != 2'd1);  // R10

   AST_REC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && low_s && ok_s && !uv_flag_o && !cpf_flag_o && oc_i == '0)
         |=> (state_o != 2'd2 && !uv_flag_o));  // R11
endmodule

bind uv_motion_supervisor uvs_checker #(.OC_NUM(OC_NUM)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .low_s        (low_s),
   .ok_s         (ok_s),
   .oc_i         (oc_i),
   .hs_done_i    (hs_done_i),
   .state_o      (state_o),
   .pwm_en_o     (pwm_en_o),
   .bridge_hiz_o (bridge_hiz_o),
   .uv_flag_o    (uv_flag_o),
   .cpf_flag_o   (cpf_flag_o),
   .sl_flag_o    (sl_flag_o),
   .tgt_wr_o     (tgt_wr_o)
);

// File: tb/uv_motion_supervisor_tb.sv
module uv_motion_supervisor_tb;
   localparam int CLK_PERIOD = 10;
   localparam int POS_W      = 16;
   localparam int OC_NUM     = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              supply_low = 1'b0, supply_ok = 1'b1, cp_fail = 1'b0;
   logic              step_loss = 1'b0, hs_done = 1'b0;
   logic [OC_NUM-1:0] oc = '0;
   logic [POS_W-1:0]  target = '0, actual = '0;
   logic [1:0]        state;
   logic              pwm_en, hiz, hs_req, uv_f, cpf_f, sl_f, wr;
   logic [POS_W-1:0]  wr_data;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   uv_motion_supervisor #(.POS_W(POS_W), .OC_NUM(OC_NUM), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low), .supply_ok_i(supply_ok),
      .cp_fail_i(cp_fail), .oc_i(oc), .step_loss_i(step_loss), .hs_done_i(hs_done),
      .target_pos_i(target), .actual_pos_i(actual), .state_o(state),
      .pwm_en_o(pwm_en), .bridge_hiz_o(hiz), .hs_req_o(hs_req), .uv_flag_o(uv_f),
      .cpf_flag_o(cpf_f), .sl_flag_o(sl_f), .tgt_wr_o(wr), .tgt_wr_data_o(wr_data)
   );

   // Behavioural reference model: states 0 stop, 1 goto, 2 hard stop, 3 shutdown
   int m_st;
   bit m_uv, m_cpf, m_sl;
   bit lq[2];
   bit oq[2];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_uv = 0; m_cpf = 0; m_sl = 0;
         lq[0] = 0; lq[1] = 0; oq[0] = 0; oq[1] = 0;
      end else begin
         bit rec, drp, cause, uvset, clr;
         int nst;
         rec = oq[1];
         drp = lq[1] && !oq[1];
         cause = m_uv || m_cpf || (oc != 0);
         uvset = 0;
         nst = m_st;
         if (m_st == 0) begin
            if (drp || m_uv) nst = 3;
            else if (target != actual && !m_sl && !cause) nst = 1;
         end else if (m_st == 1) begin
            if (drp) begin nst = 2; uvset = 1; end
            else if (cause) nst = 2;
            else if (target == actual) nst = 0;
         end else if (m_st == 2) begin
            if (drp) uvset = 1;
            if (hs_done) nst = 0;
         end else begin
            if (rec) nst = 0;
         end
         clr = (m_st == 3) && rec;
         m_uv  = clr ? 1'b0 : (m_uv || uvset);
         m_cpf = clr ? 1'b0 : (m_cpf || cp_fail);
         m_sl  = clr ? 1'b0 : (m_sl || step_loss);
         m_st  = nst;
         lq[1] = lq[0]; lq[0] = supply_low;
         oq[1] = oq[0]; oq[0] = supply_ok;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cmp_all();
      int e_wr;
      e_wr = (m_st == 2 && hs_done && !m_uv) ? 1 : 0;
      chk(cur_req, "model state", int'(state), m_st);
      chk("R12", "model pwm", int'(pwm_en), (m_st == 1 || m_st == 2) ? 1 : 0);
      chk("R3", "model hiz", int'(hiz), (m_st == 3) ? 1 : 0);
      chk("R12", "model hs_req", int'(hs_req), (m_st == 2) ? 1 : 0);
      chk(cur_req, "model uv", int'(uv_f), int'(m_uv));
      chk(cur_req, "model cpf", int'(cpf_f), int'(m_cpf));
      chk(cur_req, "model sl", int'(sl_f), int'(m_sl));
      chk("R6", "model wr", int'(wr), e_wr);
      if (e_wr == 1) chk("R6", "model wr data", int'(wr_data), int'(actual));
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmp_all();
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1", "reset state", int'(state), 0);
      chk("R1", "reset pwm", int'(pwm_en), 0);
      chk("R1", "reset flags", int'({uv_f, cpf_f, sl_f, hiz, hs_req, wr}), 0);
      rst_n = 1'b1;
      step(3);

      // R9: start and finish a move
      cur_req = "R9";
      target = 16'd10;
      step(1); chk("R9", "start move", int'(state), 1);
      actual = 16'd10;
      step(1); chk("R9", "move done", int'(state), 0);

      // R2 / R3: drop while stopped, three-edge latency
      cur_req = "R3";
      supply_low = 1'b1; supply_ok = 1'b0;
      step(2); chk("R2", "no early reaction", int'(state), 0);
      step(1); chk("R3", "shutdown", int'(state), 3);
      chk("R3", "bridge hiz", int'(hiz), 1);
      chk("R3", "pwm off", int'(pwm_en), 0);
      cur_req = "R8";
      supply_low = 1'b0; supply_ok = 1'b1;
      step(3); chk("R8", "recovered", int'(state), 0);

      // R4 / R6 / R7 / R8: drop during a move, target kept, resume
      cur_req = "R4";
      target = 16'd20;
      step(1); chk("R9", "move 2", int'(state), 1);
      supply_low = 1'b1; supply_ok = 1'b0;
      step(3); chk("R4", "hard stop", int'(state), 2);
      chk("R4", "uv latched", int'(uv_f), 1);
      chk("R12", "hs_req", int'(hs_req), 1);
      cur_req = "R6";
      hs_done = 1'b1; #1;
      chk("R6", "no write with uv", int'(wr), 0);
      step(1); chk("R6", "stopped", int'(state), 0);
      hs_done = 1'b0;
      cur_req = "R7";
      step(1); chk("R7", "to shutdown keeping target", int'(state), 3);
      cur_req = "R8";
      supply_low = 1'b0; supply_ok = 1'b1;
      step(3); chk("R8", "flags cleared", int'(uv_f), 0);
      step(1); chk("R8", "move resumes", int'(state), 1);
      actual = 16'd20;
      step(1);

      // R5 / R6: overcurrent stop cancels move
      cur_req = "R5";
      target = 16'd30;
      step(1);
      oc = 2'b01;
      step(1); chk("R5", "oc hard stop", int'(state), 2);
      oc = '0;
      cur_req = "R6";
      hs_done = 1'b1; #1;
      chk("R6", "write strobe", int'(wr), 1);
      chk("R6", "write data", int'(wr_data), 20);
      step(1); hs_done = 1'b0;
      target = 16'd20;
      step(1); chk("R6", "stays stopped", int'(state), 0);

      // R5: charge-pump fail latched, blocks motion until recovery
      cur_req = "R5";
      target = 16'd40;
      step(1);
      cp_fail = 1'b1;
      step(1); cp_fail = 1'b0;
      chk("R5", "cpf latched", int'(cpf_f), 1);
      step(1); chk("R5", "cpf hard stop", int'(state), 2);
      hs_done = 1'b1;
      step(1); hs_done = 1'b0;
      step(3); chk("R5", "cpf blocks move", int'(state), 0);
      supply_low = 1'b1; supply_ok = 1'b0;
      step(3);
      cur_req = "R8";
      supply_low = 1'b0; supply_ok = 1'b1;
      step(3); chk("R8", "cpf cleared", int'(cpf_f), 0);
      step(1); chk("R8", "move after clear", int'(state), 1);
      actual = 16'd40;
      step(1);

      // R10: step loss blocks motion
      cur_req = "R10";
      step_loss = 1'b1;
      step(1); step_loss = 1'b0;
      target = 16'd50;
      step(3); chk("R10", "step loss blocks", int'(state), 0);
      chk("R10", "sl latched", int'(sl_f), 1);
      supply_low = 1'b1; supply_ok = 1'b0;
      step(3);
      cur_req = "R8";
      supply_low = 1'b0; supply_ok = 1'b1;
      step(3); chk("R8", "sl cleared", int'(sl_f), 0);
      step(1); chk("R10", "move after clear", int'(state), 1);

      // R11: coincident drop and recovery
      cur_req = "R11";
      supply_low = 1'b1; supply_ok = 1'b1;
      step(4); chk("R11", "move continues", int'(state), 1);
      chk("R11", "no uv", int'(uv_f), 0);
      supply_low = 1'b0; actual = 16'd50;
      step(1); chk("R9", "stop", int'(state), 0);
      supply_low = 1'b1; supply_ok = 1'b0;
      step(3); chk("R3", "shutdown again", int'(state), 3);
      supply_ok = 1'b1;
      step(3); chk("R11", "recovery wins", int'(state), 0);
      supply_low = 1'b0;
      step(3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule